// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block sits between a bank of external interrupt lines and an on-chip interrupt fabric. Each pin owns a 64-bit redirection entry. The entry sets the vector, the delivery mode, the destination and its mode, edge or level triggering, and a mask bit. The engine keeps one pending bit per pin. Edge pins latch a pending request on a rising transition. Level pins follow their input. Whenever one or more unmasked pins are pending, the engine turns the lowest-numbered eligible pin into a single interrupt message. That message leaves on a valid/ready channel.

A level entry that has been delivered raises its remote-pending flag. It is not delivered again until an end-of-interrupt carrying its vector clears that flag. If the input is still high at that point, the pin is serviced again. Delivery mode 3'b111 does not take its vector from the table. Instead it asks a legacy controller through a request/acknowledge pair and uses the vector returned with the acknowledge. The table is written through a 32-bit half-entry port shared with the register interface, and read back through a combinational read port.

Top module: `irq_redirect_engine`

## Requirements
- R1: After reset every entry reads 64'h0000_0000_0001_0000 (only the mask bit 16 set), and msg_valid and ext_req are low.
- R2: Input line 0 drives pin 2 (ORed with line 2). Pin 0 never becomes pending. Every other line drives the pin with the same index.
- R3: A pin whose entry has bit 15 = 0 (edge) becomes pending on a 0-to-1 input transition only if bit 16 (mask) is 0. An edge seen while masked is discarded and is not delivered after a later unmask.
- R4: A pin with bit 15 = 1 (level) has its pending bit follow the input. If the input falls before delivery, the request is withdrawn.
- R5: Delivering a level entry sets its bit 14 (remote-pending). No further message comes from that pin while bit 14 is set. Writes to the low half cannot change bit 14.
- R6: An end-of-interrupt with vector V clears bit 14 of every entry whose bit 14 is set and whose bits [7:0] equal V. If such a pin is unmasked and still pending, it is delivered again. An end-of-interrupt with a different vector has no effect.
- R7: For delivery mode 3'b111, ext_req is raised and held until ext_ack. The message then carries ext_vector. For every other mode the vector is entry bits [7:0]. ext_req and msg_valid are never high together.
- R8: A message carries destination from bits [63:56], destination mode from bit 11, delivery mode from bits [10:8], and msg_level equal to bit 15.
- R9: While msg_valid is high and msg_ready is low, the message holds stable. Requests that arrive meanwhile stay pending and are delivered later.
- R10: When several pins are eligible, the lowest pin index is delivered first.
- R11: An edge delivery clears its pending bit, so one edge yields one message. Writing an entry takes effect at once: unmasking a pending level pin delivers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 24 | External interrupt lines |
| tbl_wr_en | input | 1 | Table half-entry write strobe |
| tbl_wr_idx | input | 5 | Entry index for write (indices >= 24 ignored) |
| tbl_wr_hi | input | 1 | 1 writes bits [63:32], 0 writes bits [31:0] |
| tbl_wr_data | input | 32 | Write data |
| tbl_rd_idx | input | 5 | Entry index for readback |
| tbl_rd_data | output | 64 | Entry contents (0 for out-of-range index) |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | End-of-interrupt vector |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted by fabric |
| msg_dest | output | 8 | Destination |
| msg_dest_mode | output | 1 | Destination mode |
| msg_deliv_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Interrupt vector |
| msg_level | output | 1 | 1 for level-triggered source |
| ext_req | output | 1 | Vector request to legacy controller |
| ext_ack | input | 1 | Legacy controller acknowledge |
| ext_vector | input | 8 | Vector supplied with ext_ack |

## Verification
Single edge pulses on unmasked and masked pins separate true edge capture from mask-gated discard, and show that one edge gives one message. A held level input, followed by end-of-interrupts with a wrong and then the right vector, separates the remote-pending gate from plain pending tracking. A level pulse that drops while masked shows the request is withdrawn. Two simultaneous edges under back-pressure show both the ascending priority and that no request is lost while the channel stalls. A pulse on line 0 with entry 0 also armed proves the line-to-pin remap, and a legacy-mode entry proves the vector comes from the acknowledge and not from the table.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // entry field positions (decoded by the delivery message builder)
  localparam int unsigned VEC_LO  = 0;
  localparam int unsigned DM_LO   = 8;
  localparam int unsigned DSTM_B  = 11;
  localparam int unsigned RPEND_B = 14;
  localparam int unsigned TRIG_B  = 15;
  localparam int unsigned MASK_B  = 16;
  localparam int unsigned DEST_LO = 56;

  localparam logic [2:0]  DM_LEGACY   = 3'b111;
  localparam logic [63:0] ENTRY_RESET = 64'h1 << MASK_B;

  typedef struct packed {
    logic [7:0] dest;
    logic       dest_mode;
    logic [2:0] deliv;
    logic [7:0] vector;
    logic       level;
  } irq_msg_t;

  function automatic irq_msg_t build_msg(input logic [63:0] e);
    irq_msg_t m;
    m.dest      = e[DEST_LO +: 8];
    m.dest_mode = e[DSTM_B];
    m.deliv     = e[DM_LO +: 3];
    m.vector    = e[VEC_LO +: 8];
    m.level     = e[TRIG_B];
    return m;
  endfunction

  function automatic logic eoi_hit(input logic [63:0] e, input logic [7:0] v);
    return e[RPEND_B] && (e[VEC_LO +: 8] == v);
  endfunction
endpackage

// File: rtl/irq_pin_front.sv
module irq_pin_front #(
  parameter int unsigned N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] mask_v,
  input  logic [N-1:0] level_v,
  input  logic [N-1:0] edge_clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] pin_lvl;
  logic [N-1:0] prev_lvl;
  logic [N-1:0] edge_set;
  logic [N-1:0] pend_nxt;

  for (genvar i = 0; i < N; i++) begin : g_map
    if (i == 0) begin : g_zero
      assign pin_lvl[i] = 1'b0;
    end else if (i == 2) begin : g_remap
      assign pin_lvl[i] = irq_in[0] | irq_in[2];
    end else begin : g_direct
      assign pin_lvl[i] = irq_in[i];
    end
  end

  assign edge_set = pin_lvl & ~prev_lvl & ~mask_v;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (level_v[i]) pend_nxt[i] = pin_lvl[i];
      else            pend_nxt[i] = (pend[i] & ~edge_clr[i]) | edge_set[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_lvl <= '0;
      pend     <= '0;
    end else begin
      prev_lvl <= pin_lvl;
      pend     <= pend_nxt;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R3
    masked_edge_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_v[i] && mask_v[i] && !pend[i]) |=> !pend[i]);
  end
endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_route_pkg::*;
#(
  parameter int unsigned N  = 24,
  parameter int unsigned IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_hi,
  input  logic [31:0]   wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [63:0]   rd_data,
  input  logic [IW-1:0] sel_idx,
  output irq_msg_t      sel_msg,
  input  logic          launch,
  input  logic          eoi_valid,
  input  logic [7:0]    eoi_vector,
  output logic [N-1:0]  mask_v,
  output logic [N-1:0]  level_v,
  output logic [N-1:0]  remote_v
);
  logic [63:0] tbl     [N];
  logic [63:0] tbl_nxt [N];
  logic        unused_wr_bit;

  assign unused_wr_bit = wr_data[RPEND_B];

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_comb begin
      tbl_nxt[i] = tbl[i];
      if (wr_en && wr_idx == IW'(i)) begin
        if (wr_hi) tbl_nxt[i][63:32] = wr_data;
        else       tbl_nxt[i][31:0]  = wr_data;
      end
      // remote-pending is not writable: EOI clears it, a level launch sets it
      tbl_nxt[i][RPEND_B] = tbl[i][RPEND_B];
      if (eoi_valid && eoi_hit(tbl[i], eoi_vector)) tbl_nxt[i][RPEND_B] = 1'b0;
      if (launch && sel_idx == IW'(i) && tbl[i][TRIG_B]) tbl_nxt[i][RPEND_B] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) tbl[i] <= ENTRY_RESET;
      else        tbl[i] <= tbl_nxt[i];
    end

    assign mask_v[i]   = tbl[i][MASK_B];
    assign level_v[i]  = tbl[i][TRIG_B];
    assign remote_v[i] = tbl[i][RPEND_B];

    // R5
    remote_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(remote_v[i]) |-> $past(launch && sel_idx == IW'(i)));
  end

  assign rd_data = (rd_idx < IW'(N)) ? tbl[rd_idx] : 64'h0;
  assign sel_msg = build_msg(tbl[sel_idx]);
endmodule

// File: rtl/irq_scan_dispatch.sv
module irq_scan_dispatch
  import irq_route_pkg::*;
#(
  parameter int unsigned N  = 24,
  parameter int unsigned IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  mask_v,
  input  logic [N-1:0]  level_v,
  input  logic [N-1:0]  remote_v,
  input  irq_msg_t      sel_msg,
  output logic [IW-1:0] sel_idx,
  output logic          launch,
  output logic [N-1:0]  edge_clr,
  output logic          msg_valid,
  input  logic          msg_ready,
  output irq_msg_t      msg_q,
  output logic          ext_req,
  input  logic          ext_ack,
  input  logic [7:0]    ext_vector
);
  logic [N-1:0] elig;
  logic         any_elig;

  function automatic logic [IW-1:0] lowest_set(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int k = N - 1; k >= 0; k--) if (v[k]) r = IW'(k);
    return r;
  endfunction

  assign elig     = pend & ~mask_v & ~(level_v & remote_v);
  assign any_elig = |elig;
  assign sel_idx  = lowest_set(elig);
  assign launch   = any_elig && !msg_valid && !ext_req;

  for (genvar i = 0; i < N; i++) begin : g_clr
    assign edge_clr[i] = launch && sel_idx == IW'(i) && !level_v[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      ext_req   <= 1'b0;
      msg_q     <= '0;
    end else begin
      if (msg_valid && msg_ready) msg_valid <= 1'b0;
      if (ext_req && ext_ack) begin
        ext_req      <= 1'b0;
        msg_valid    <= 1'b1;
        msg_q.vector <= ext_vector;
      end
      if (launch) begin
        msg_q <= sel_msg;
        if (sel_msg.deliv == DM_LEGACY) ext_req   <= 1'b1;
        else                            msg_valid <= 1'b1;
      end
    end
  end

  // R9
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_q)));
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> ext_req);
  // R7
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_req && msg_valid));
  // R10
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (sel_idx < IW'(N)) && pend[sel_idx]);
endmodule

// File: rtl/irq_redirect_engine.sv
module irq_redirect_engine
  import irq_route_pkg::*;
#(
  parameter int unsigned N_PINS = 24,
  localparam int unsigned IW    = $clog2(N_PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] irq_in,
  input  logic              tbl_wr_en,
  input  logic [IW-1:0]     tbl_wr_idx,
  input  logic              tbl_wr_hi,
  input  logic [31:0]       tbl_wr_data,
  input  logic [IW-1:0]     tbl_rd_idx,
  output logic [63:0]       tbl_rd_data,
  input  logic              eoi_valid,
  input  logic [7:0]        eoi_vector,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_dest,
  output logic              msg_dest_mode,
  output logic [2:0]        msg_deliv_mode,
  output logic [7:0]        msg_vector,
  output logic              msg_level,
  output logic              ext_req,
  input  logic              ext_ack,
  input  logic [7:0]        ext_vector
);
  logic [N_PINS-1:0] pend, mask_v, level_v, remote_v, edge_clr;
  logic [IW-1:0]     sel_idx;
  logic              launch;
  irq_msg_t          sel_msg, msg_q;

  irq_pin_front #(.N(N_PINS)) u_front (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_v(mask_v),
    .level_v(level_v), .edge_clr(edge_clr), .pend(pend)
  );

  irq_redir_table #(.N(N_PINS), .IW(IW)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx),
    .wr_hi(tbl_wr_hi), .wr_data(tbl_wr_data), .rd_idx(tbl_rd_idx),
    .rd_data(tbl_rd_data), .sel_idx(sel_idx), .sel_msg(sel_msg),
    .launch(launch), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .mask_v(mask_v), .level_v(level_v), .remote_v(remote_v)
  );

  irq_scan_dispatch #(.N(N_PINS), .IW(IW)) u_dispatch (
    .clk(clk), .rst_n(rst_n), .pend(pend), .mask_v(mask_v),
    .level_v(level_v), .remote_v(remote_v), .sel_msg(sel_msg),
    .sel_idx(sel_idx), .launch(launch), .edge_clr(edge_clr),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_q(msg_q),
    .ext_req(ext_req), .ext_ack(ext_ack), .ext_vector(ext_vector)
  );

  assign msg_dest       = msg_q.dest;
  assign msg_dest_mode  = msg_q.dest_mode;
  assign msg_deliv_mode = msg_q.deliv;
  assign msg_vector     = msg_q.vector;
  assign msg_level      = msg_q.level;
endmodule

// File: tb/irq_redirect_engine_bench.sv
`timescale 1ns/100ps
module irq_redirect_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] irq_in = '0;
  logic        tbl_wr_en = 1'b0, tbl_wr_hi = 1'b0;
  logic [4:0]  tbl_wr_idx = '0, tbl_rd_idx = '0;
  logic [31:0] tbl_wr_data = '0;
  logic [63:0] tbl_rd_data;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;
  logic        msg_valid, msg_dest_mode, msg_level, ext_req;
  logic        msg_ready = 1'b1, ext_ack = 1'b0;
  logic [7:0]  msg_dest, msg_vector, ext_vector = 8'h9A;
  logic [2:0]  msg_deliv_mode;

  int checks = 0, fails = 0, cycles = 0;
  bit saw_req = 0;

  always #2.5 clk = ~clk;

  irq_redirect_engine u_irq_redirect_engine (.*);

  // legacy controller model: answers every request on the next cycle
  initial forever begin
    @(negedge clk);
    ext_ack = ext_req;
    if (ext_req) saw_req = 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lo_word(input logic [7:0] vec, input logic [2:0] dm,
                                          input logic dstm, input logic lvl, input logic msk);
    return {15'b0, msk, lvl, 1'b0, 2'b0, dstm, dm, vec};
  endfunction

  task automatic wr(input int idx, input bit hi, input logic [31:0] d);
    @(negedge clk);
    tbl_wr_en = 1; tbl_wr_idx = 5'(idx); tbl_wr_hi = hi; tbl_wr_data = d;
    @(negedge clk);
    tbl_wr_en = 0;
  endtask

  task automatic cfg(input int idx, input logic [7:0] vec, input logic [2:0] dm, input logic dstm,
                     input logic lvl, input logic msk, input logic [7:0] dest);
    wr(idx, 1, {dest, 24'h0});
    wr(idx, 0, lo_word(vec, dm, dstm, lvl, msk));
  endtask

  task automatic pulse(input int line);
    @(negedge clk); irq_in[line] = 1;
    @(negedge clk); irq_in[line] = 0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1; eoi_vector = v;
    @(negedge clk); eoi_valid = 0;
  endtask

  task automatic rd(input int idx, output logic [63:0] v);
    tbl_rd_idx = 5'(idx); #0.1; v = tbl_rd_data;
  endtask

  task automatic wait_msg(input string req, input logic [7:0] vec, input logic [7:0] dest,
                          input logic dstm, input logic [2:0] dm, input logic lvl);
    bit got = 0;
    logic [20:0] exp, act;
    exp = {dest, dstm, dm, vec, lvl};
    for (int k = 0; k < 60 && !got; k++) begin
      @(negedge clk);
      if (msg_valid) got = 1;
    end
    act = got ? {msg_dest, msg_dest_mode, msg_deliv_mode, msg_vector, msg_level} : '0;
    chk(got && act == exp, req, 64'(act), 64'(exp));
  endtask

  task automatic no_msg(input string req, input int n);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (msg_valid) seen++;
    end
    chk(seen == 0, req, 64'(seen), 64'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(0, v);  chk(v == 64'h10000, "R1 entry0", v, 64'h10000);
    rd(23, v); chk(v == 64'h10000, "R1 entry23", v, 64'h10000);
    chk(!msg_valid && !ext_req, "R1 outputs idle", {msg_valid, ext_req}, 0);

    // R3 R8 R11 edge delivery, one message per edge
    cfg(5, 8'h35, 3'b000, 1, 0, 0, 8'h12);
    rd(5, v); chk(v == {8'h12, 24'h0, lo_word(8'h35, 0, 1, 0, 0)}, "R11 entry write readback",
                  v, {8'h12, 24'h0, lo_word(8'h35, 0, 1, 0, 0)});
    pulse(5);
    wait_msg("R8 edge message fields", 8'h35, 8'h12, 1, 3'b000, 0);
    no_msg("R11 single message per edge", 30);

    // R3 masked edge discarded
    cfg(6, 8'h36, 3'b000, 0, 0, 1, 8'h00);
    pulse(6);
    wr(6, 0, lo_word(8'h36, 0, 0, 0, 0));
    no_msg("R3 masked edge discarded", 30);

    // R2 line 0 goes to pin 2, pin 0 silent
    cfg(2, 8'h22, 3'b001, 0, 0, 0, 8'h02);
    cfg(0, 8'h20, 3'b000, 0, 0, 0, 8'h00);
    pulse(0);
    wait_msg("R2 line0 to pin2", 8'h22, 8'h02, 0, 3'b001, 0);
    no_msg("R2 pin0 never pending", 30);

    // R5 R6 level with remote-pending
    cfg(7, 8'h47, 3'b000, 0, 1, 0, 8'h07);
    @(negedge clk); irq_in[7] = 1;
    wait_msg("R5 level delivery", 8'h47, 8'h07, 0, 3'b000, 1);
    rd(7, v); chk(v[14] == 1'b1, "R5 remote flag set", 64'(v[14]), 1);
    no_msg("R5 no redelivery while remote set", 30);
    eoi(8'h48);
    no_msg("R6 wrong-vector eoi ignored", 20);
    rd(7, v); chk(v[14] == 1'b1, "R6 remote kept on wrong eoi", 64'(v[14]), 1);
    eoi(8'h47);
    wait_msg("R6 eoi redelivers pending level", 8'h47, 8'h07, 0, 3'b000, 1);
    @(negedge clk); irq_in[7] = 0;
    repeat (3) @(negedge clk);
    eoi(8'h47);
    no_msg("R6 eoi after input low", 20);
    rd(7, v); chk(v[14] == 1'b0, "R6 remote cleared", 64'(v[14]), 0);

    // R4 level withdrawn before unmask
    cfg(14, 8'h4E, 3'b000, 0, 1, 1, 8'h0E);
    @(negedge clk); irq_in[14] = 1;
    repeat (3) @(negedge clk);
    irq_in[14] = 0;
    repeat (2) @(negedge clk);
    wr(14, 0, lo_word(8'h4E, 0, 0, 1, 0));
    no_msg("R4 level low withdraws request", 30);

    // R11 unmask via write delivers a pending level pin
    cfg(13, 8'h4D, 3'b000, 0, 1, 1, 8'h0D);
    @(negedge clk); irq_in[13] = 1;
    no_msg("R11 masked level held", 10);
    wr(13, 0, lo_word(8'h4D, 0, 0, 1, 0));
    wait_msg("R11 unmask write delivers", 8'h4D, 8'h0D, 0, 3'b000, 1);
    @(negedge clk); irq_in[13] = 0;
    eoi(8'h4D);

    // R5 remote flag not writable
    wr(15, 0, lo_word(8'h4F, 0, 0, 1, 1) | 32'h4000);
    rd(15, v); chk(v[31:0] == lo_word(8'h4F, 0, 0, 1, 1), "R5 remote not writable",
                   64'(v[31:0]), 64'(lo_word(8'h4F, 0, 0, 1, 1)));

    // R9 R10 priority and back-pressure
    cfg(9, 8'h59, 3'b000, 0, 0, 0, 8'h09);
    cfg(4, 8'h54, 3'b000, 0, 0, 0, 8'h04);
    @(negedge clk); msg_ready = 0; irq_in[9] = 1; irq_in[4] = 1;
    @(negedge clk); irq_in[9] = 0; irq_in[4] = 0;
    wait_msg("R10 lowest pin first", 8'h54, 8'h04, 0, 3'b000, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(msg_valid && msg_vector == 8'h54, "R9 held under back-pressure",
          {msg_valid, msg_vector}, {1'b1, 8'h54});
    end
    msg_ready = 1;
    @(negedge clk);
    wait_msg("R9 stalled request not lost", 8'h59, 8'h09, 0, 3'b000, 0);

    // R7 legacy-controller vector
    cfg(11, 8'h00, 3'b111, 0, 0, 0, 8'h33);
    saw_req = 0;
    pulse(11);
    wait_msg("R7 vector from acknowledge", 8'h9A, 8'h33, 0, 3'b111, 0);
    chk(saw_req, "R7 request raised", 64'(saw_req), 1);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule